// File: doc/BRIEF.md
# GPIO port register controller

This block controls a 16-pin general-purpose I/O port through a small memory-mapped register file. Software sets up each pin through a 4-bit field that selects output or input and the flavour of each. The block turns those fields into per-pin output-enable, output-level and pull-up/pull-down controls for the pad ring. It also returns the sampled pin levels through a read-only input register.

Output bits can be written whole through the output data register. They can also be changed atomically, bit by bit, through a write-only set/clear register, which avoids read-modify-write races between software tasks. Pin inputs cross into the clock domain through a two-stage synchroniser.

Top module: `gpio_port_ctrl`

## Requirements
- R1: While `rst_n` is low, both configuration registers hold 0x44444444 and the output data register holds 0. With that configuration every pin has `pin_oe`, `pin_out`, `pin_pu` and `pin_pd` low.
- R2: Pin n (0..7) is configured by bits [4n+3:4n] of the low configuration register at offset 0x00. Pin n (8..15) is configured by bits [4(n-8)+3:4(n-8)] of the high configuration register at offset 0x04. Within a field, bits [3:2] are the type (CNF) and bits [1:0] are the direction/speed (MODE). Both registers read back all 32 bits as written, and a write to one leaves the other unchanged.
- R3: A pin with MODE 01, 10 or 11 and CNF bit 0 clear is a push-pull output: `pin_oe`=1 and `pin_out` equals its output data bit. The three nonzero MODE codes behave identically.
- R4: A pin with nonzero MODE and CNF bit 0 set is open-drain: `pin_out`=0 and `pin_oe` is the inverse of its output data bit.
- R5: A pin with MODE 00 is an input with `pin_oe`=0 and `pin_out`=0. With CNF=10, `pin_pu` equals its output data bit and `pin_pd` its inverse. With any other CNF, both pull controls are 0.
- R6: The output data register at offset 0x0C takes bits [15:0] of a write as the pin output bits. Bits [31:16] ignore writes and read as zero.
- R7: A write to offset 0x10 sets output bit k for each 1 in data bit k (k=0..15) and clears output bit k for each 1 in data bit k+16. Bits with both zero are unchanged. When both bits are 1 the bit is set. The register reads as zero.
- R8: The input data register at offset 0x08 returns in bits [15:0] the pin levels sampled two clock edges earlier, with bits [31:16] zero. A pin configured as analog input (field 0000) reads 0 there. Writes to it have no effect.
- R9: Offsets 0x14 to 0x1C, and any address with bits [1:0] nonzero, read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W (5) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 16 | Pin levels from the pads |
| pin_oe | output | 16 | Per-pin output enable |
| pin_out | output | 16 | Per-pin driven level |
| pin_pu | output | 16 | Per-pin pull-up enable |
| pin_pd | output | 16 | Per-pin pull-down enable |

## Verification
The bench aims at a set/clear write that asserts both halves for the same pin. A design with the wrong priority would leave that bit low. It checks that a pulled input follows its output data bit: swapping the polarity turns a pull-up into a pull-down. It writes every MODE code to catch a decoder that treats only one speed grade as an output. It also reads the input register one edge after a pin change and again after two, which exposes a synchroniser with a stage too few or too many. Misaligned addresses, unmapped offsets, writes to the upper half of the output register and analog pins are included, because each can leak stray bits into a register or a readback.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int NPIN    = 16;
  localparam int FIELD_W = 4;
  localparam int WORD_W  = 32;
  localparam int PIN_PER_REG = WORD_W / FIELD_W;

  localparam int OFF_CFG_LO = 'h00;
  localparam int OFF_CFG_HI = 'h04;
  localparam int OFF_IN     = 'h08;
  localparam int OFF_OUT    = 'h0C;
  localparam int OFF_SETCLR = 'h10;

  localparam logic [WORD_W-1:0] CFG_RESET = 32'h4444_4444;

  typedef struct packed {
    logic [1:0] kind;   // CNF
    logic [1:0] dir;    // MODE: 00 input, else output
  } pin_cfg_t;

  typedef struct packed {
    logic oe;
    logic drv;
    logic pu;
    logic pd;
    logic analog;
  } pin_ctl_t;

  function automatic pin_ctl_t decode_pin(input pin_cfg_t c, input logic obit);
    pin_ctl_t r;
    r = '0;
    if (c.dir != 2'b00) begin
      if (c.kind[0]) begin
        r.oe  = ~obit;
        r.drv = 1'b0;
      end else begin
        r.oe  = 1'b1;
        r.drv = obit;
      end
    end else begin
      r.analog = (c.kind == 2'b00);
      if (c.kind == 2'b10) begin
        r.pu = obit;
        r.pd = ~obit;
      end
    end
    return r;
  endfunction

  function automatic logic [NPIN-1:0] apply_setclr(input logic [NPIN-1:0] cur,
                                                   input logic [NPIN-1:0] set,
                                                   input logic [NPIN-1:0] clr);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [NPIN-1:0]   idr,
  output logic [WORD_W-1:0] rdata,
  output logic [WORD_W-1:0] cfg_lo_q,
  output logic [WORD_W-1:0] cfg_hi_q,
  output logic [NPIN-1:0]   odr_q,
  output logic              cfg_lo_wr,
  output logic              cfg_hi_wr,
  output logic              odr_wr,
  output logic              sc_wr,
  output logic [NPIN-1:0]   sc_set,
  output logic [NPIN-1:0]   sc_clr
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] I_LO  = IDX_W'(OFF_CFG_LO / 4);
  localparam logic [IDX_W-1:0] I_HI  = IDX_W'(OFF_CFG_HI / 4);
  localparam logic [IDX_W-1:0] I_IN  = IDX_W'(OFF_IN / 4);
  localparam logic [IDX_W-1:0] I_OUT = IDX_W'(OFF_OUT / 4);
  localparam logic [IDX_W-1:0] I_SC  = IDX_W'(OFF_SETCLR / 4);

  logic [IDX_W-1:0] idx;
  logic             aligned;

  assign idx     = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);

  assign cfg_lo_wr = wr && aligned && (idx == I_LO);
  assign cfg_hi_wr = wr && aligned && (idx == I_HI);
  assign odr_wr    = wr && aligned && (idx == I_OUT);
  assign sc_wr     = wr && aligned && (idx == I_SC);
  assign sc_set    = wdata[NPIN-1:0];
  assign sc_clr    = wdata[2*NPIN-1:NPIN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_lo_q <= CFG_RESET;
      cfg_hi_q <= CFG_RESET;
      odr_q    <= '0;
    end else begin
      if (cfg_lo_wr) cfg_lo_q <= wdata;
      if (cfg_hi_wr) cfg_hi_q <= wdata;
      if (sc_wr)       odr_q <= apply_setclr(odr_q, sc_set, sc_clr);
      else if (odr_wr) odr_q <= wdata[NPIN-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (aligned) begin
      unique case (idx)
        I_LO:    rdata = cfg_lo_q;
        I_HI:    rdata = cfg_hi_q;
        I_IN:    rdata = {{(WORD_W-NPIN){1'b0}}, idr};
        I_OUT:   rdata = {{(WORD_W-NPIN){1'b0}}, odr_q};
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_pin_ctl.sv
module gpio_pin_ctl
  import gpio_pkg::*;
(
  input  logic [FIELD_W-1:0] field,
  input  logic               obit,
  output logic               oe,
  output logic               drv,
  output logic               pu,
  output logic               pd,
  output logic               analog
);
  pin_ctl_t ctl;

  assign ctl    = decode_pin(pin_cfg_t'(field), obit);
  assign oe     = ctl.oe;
  assign drv    = ctl.drv;
  assign pu     = ctl.pu;
  assign pd     = ctl.pd;
  assign analog = ctl.analog;
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [15:0]       pin_in,
  output logic [15:0]       pin_oe,
  output logic [15:0]       pin_out,
  output logic [15:0]       pin_pu,
  output logic [15:0]       pin_pd
);
  logic [WORD_W-1:0] cfg_lo_q, cfg_hi_q;
  logic [NPIN-1:0]   odr_q;
  logic              cfg_lo_wr, cfg_hi_wr, odr_wr, sc_wr;
  logic [NPIN-1:0]   sc_set, sc_clr;
  logic [NPIN-1:0]   sync_q, analog_mask, idr;

  gpio_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (bus_wr),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .idr       (idr),
    .rdata     (bus_rdata),
    .cfg_lo_q  (cfg_lo_q),
    .cfg_hi_q  (cfg_hi_q),
    .odr_q     (odr_q),
    .cfg_lo_wr (cfg_lo_wr),
    .cfg_hi_wr (cfg_hi_wr),
    .odr_wr    (odr_wr),
    .sc_wr     (sc_wr),
    .sc_set    (sc_set),
    .sc_clr    (sc_clr)
  );

  gpio_in_sync #(.W(NPIN)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (sync_q)
  );

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic [FIELD_W-1:0] field;
    if (p < PIN_PER_REG) begin : g_lo
      assign field = cfg_lo_q[FIELD_W*p +: FIELD_W];
    end else begin : g_hi
      assign field = cfg_hi_q[FIELD_W*(p-PIN_PER_REG) +: FIELD_W];
    end
    gpio_pin_ctl u_ctl (
      .field  (field),
      .obit   (odr_q[p]),
      .oe     (pin_oe[p]),
      .drv    (pin_out[p]),
      .pu     (pin_pu[p]),
      .pd     (pin_pd[p]),
      .analog (analog_mask[p])
    );
  end

  assign idr = sync_q & ~analog_mask;
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic [15:0]       pin_oe,
  input logic [15:0]       pin_out,
  input logic [15:0]       pin_pu,
  input logic [15:0]       pin_pd,
  input logic [15:0]       odr_q,
  input logic [31:0]       cfg_hi_q,
  input logic              cfg_lo_wr,
  input logic              sc_wr,
  input logic [15:0]       sc_set,
  input logic [15:0]       sc_clr
);
  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (odr_q == '0 && cfg_hi_q == 32'h4444_4444));

  assert_cfg_hi_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_lo_wr |=> $stable(cfg_hi_q));

  assert_drive_needs_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);

  assert_pull_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pu & pin_pd) == '0);

  assert_pull_input_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_pu | pin_pd) & pin_oe) == '0);

  assert_odr_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(5'h0C)) |-> (bus_rdata[31:16] == '0));

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sc_wr |=> ((odr_q & $past(sc_set)) == $past(sc_set)));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sc_wr |=> ((odr_q & $past(sc_clr & ~sc_set)) == '0));
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .pin_oe    (pin_oe),
  .pin_out   (pin_out),
  .pin_pu    (pin_pu),
  .pin_pd    (pin_pd),
  .odr_q     (odr_q),
  .cfg_hi_q  (cfg_hi_q),
  .cfg_lo_wr (cfg_lo_wr),
  .sc_wr     (sc_wr),
  .sc_set    (sc_set),
  .sc_clr    (sc_clr)
);

// File: tb/test_gpio_port_ctrl.sv
`timescale 1ns/1ps
module test_gpio_port_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_oe, pin_out, pin_pu, pin_pd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_lo, m_hi;
  logic [15:0] m_odr;

  always #2 clk = ~clk;

  gpio_port_ctrl i_gpio_port_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu), .pin_pd(pin_pd)
  );

  function automatic logic [3:0] fld(input int p);
    return (p < 8) ? m_lo[p*4 +: 4] : m_hi[(p-8)*4 +: 4];
  endfunction

  // expected {oe,out,pu,pd} of one pin from the requirement text
  function automatic logic [3:0] exp_pin(input logic [3:0] f, input logic o);
    case ({f[1:0] == 2'b00, f[2]})
      2'b00: return {1'b1, o, 2'b00};
      2'b01: return {~o, 1'b0, 2'b00};
      default: return (f[3:2] == 2'b10) ? {2'b00, o, ~o} : 4'b0000;
    endcase
  endfunction

  function automatic logic [15:0] exp_idr(input logic [15:0] lv);
    logic [15:0] r;
    for (int p = 0; p < 16; p++) r[p] = lv[p] && (fld(p) != 4'b0000);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a[1:0] == 2'b00) begin
      case (a)
        5'h00: m_lo = d;
        5'h04: m_hi = d;
        5'h0C: m_odr = d[15:0];
        5'h10: m_odr = (m_odr & ~d[31:16]) | d[15:0];
        default: ;
      endcase
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic check_pins(input string req);
    logic [15:0] eoe, eout, epu, epd;
    logic [3:0] e;
    for (int p = 0; p < 16; p++) begin
      e = exp_pin(fld(p), m_odr[p]);
      {eoe[p], eout[p], epu[p], epd[p]} = e;
    end
    chk(pin_oe == eoe, req, {16'h0, pin_oe}, {16'h0, eoe});
    chk(pin_out == eout, req, {16'h0, pin_out}, {16'h0, eout});
    chk(pin_pu == epu, req, {16'h0, pin_pu}, {16'h0, epu});
    chk(pin_pd == epd, req, {16'h0, pin_pd}, {16'h0, epd});
  endtask

  task automatic check_regs(input string req);
    logic [31:0] d;
    rd(5'h00, d); chk(d == m_lo, {req, " R2 lo"}, d, m_lo);
    rd(5'h04, d); chk(d == m_hi, {req, " R2 hi"}, d, m_hi);
    rd(5'h0C, d); chk(d == {16'h0, m_odr}, {req, " R6 odr"}, d, {16'h0, m_odr});
    rd(5'h10, d); chk(d == 0, {req, " R7 setclr reads zero"}, d, 0);
    rd(5'h14, d); chk(d == 0, {req, " R9 unmapped"}, d, 0);
    rd(5'h01, d); chk(d == 0, {req, " R9 misaligned"}, d, 0);
  endtask

  task automatic check_input(input logic [15:0] lv, input string req);
    logic [31:0] d;
    logic [15:0] old;
    old = pin_in;
    @(negedge clk);
    pin_in = lv;
    @(negedge clk);
    rd(5'h08, d);
    chk(d == {16'h0, exp_idr(old)}, {req, " R8 one edge"}, d, {16'h0, exp_idr(old)});
    @(negedge clk);
    rd(5'h08, d);
    chk(d == {16'h0, exp_idr(lv)}, {req, " R8 two edges"}, d, {16'h0, exp_idr(lv)});
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed_0417));
    m_lo = 32'h4444_4444; m_hi = 32'h4444_4444; m_odr = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check_pins("R1 reset");
    check_regs("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);

    // R3 push-pull with every nonzero mode code
    wr(5'h00, 32'h3213_2132);
    wr(5'h04, 32'h1231_3212);
    wr(5'h0C, 32'hFFFF_A5C3);
    check_pins("R3 push-pull");
    check_regs("R3/R6");
    // R4 open-drain
    wr(5'h00, 32'h7576_5765);
    check_pins("R4 open-drain");
    // R5 pulled inputs follow output bit
    wr(5'h04, 32'h8888_8888);
    check_pins("R5 pull");
    wr(5'h0C, 32'h0000_5A0F);
    check_pins("R5 pull after odr");
    // R7 set and clear on same bit: set wins
    wr(5'h10, 32'h0101_0100);
    d = {16'h0, m_odr};
    rd(5'h0C, d);
    chk(d[8] == 1'b1 && d[0] == 1'b0, "R7 set beats clear", d, {16'h0, m_odr});
    check_regs("R7");
    wr(5'h10, 32'h0000_0000);
    check_regs("R7 zero write unchanged");
    // R8 input latency and analog masking
    wr(5'h00, 32'h0000_4040);
    check_input(16'hFFFF, "R8 analog");
    check_input(16'h1234, "R8");
    // R8/R9 writes to input / unmapped / misaligned ignored
    wr(5'h08, 32'hFFFF_FFFF);
    wr(5'h14, 32'hFFFF_FFFF);
    wr(5'h1C, 32'hFFFF_FFFF);
    wr(5'h01, 32'h1111_1111);
    wr(5'h0E, 32'h0000_FFFF);
    check_regs("R9 ignored writes");
    check_pins("R9 ignored writes");

    // random phase
    for (int it = 0; it < 400; it++) begin
      logic [4:0] a;
      a = {$urandom_range(7, 0), 2'b00};
      if ($urandom_range(9, 0) == 0) a[1:0] = 2'($urandom_range(3, 1));
      wr(a, $urandom());
      check_pins("R3/R4/R5 random");
      if (it % 8 == 0) check_regs("random");
      if (it % 16 == 0) check_input(16'($urandom()), "R8 random");
    end
    done = 1;
  end

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
      wait (done);
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule